// File: doc/BRIEF.md
# Precise Exception Arbiter for a Five-Stage Pipeline

This block decides when an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) takes an exception, and which cause it takes. Faults can be raised in three places. An instruction-side translation miss is raised in fetch. An execute fault is raised in execute. A data translation miss or a data bus error is raised in the memory stage. Every cause raised early travels with its instruction until that instruction reaches the memory stage. The memory stage is the single commit point, so a fault detected late on the data side still leaves the machine in a precise state.

In the cycle an exception is committed, the block kills the memory, execute, decode and fetch stages. Older instructions already in writeback complete normally. The block redirects fetch to the handler vector, which is the exception base plus the cause code times 32. On the following clock edge it records the faulting instruction's PC and pulses a taken strobe together with the cause code. A branch flush from execute is forwarded as a fetch redirect, unless an exception is committed in the same cycle. Interrupts share the commit point and have the lowest priority.

Top module: `pexc_arbiter`

## Requirements
- R1: After reset, all kill outputs, `redirect_valid` and `exc_taken` are 0, and `epc` and `exc_id` are 0.
- R2: A fetch translation miss (`f_valid` and `f_itlb_miss` high while not stalled) is committed with cause 1 when its instruction reaches memory. This is in the cycle after the third unstalled clock edge. The miss causes no kill before then.
- R3: An execute fault (`x_valid` and `x_fault` high while not stalled) is committed with cause 4 in the cycle after the next unstalled edge.
- R4: A data translation miss (`m_valid` and `m_dtlb_miss`, not stalled) is committed with cause 2 in the same cycle. A commit drives `kill_m`, `kill_x`, `kill_d` and `kill_f` all high in that cycle.
- R5: A data bus error sets a sticky flag on an edge where `dbus_err` and `dbus_cyc` are both high. `dbus_err` without `dbus_cyc` is ignored. The flag is committed with cause 3 at the next cycle where `m_valid` is high and the pipeline is not stalled, and a commit clears the flag.
- R6: Priority at the commit point runs from bus error (3) to data translation miss (2), then a carried instruction-side cause (1 or 4), then interrupt (5). A translation miss in fetch during a data-side commit is discarded and never taken later.
- R7: When an execute fault and a memory-stage fault occur in the same cycle, the memory-stage fault is taken and the execute fault is discarded.
- R8: In a commit cycle, `redirect_valid` is 1 and `redirect_pc` equals `exc_base` + 32 × cause. This holds even when `x_branch_flush` is high in the same cycle.
- R9: A branch flush with no commit (and no stall) drives `redirect_pc` = `x_branch_target`, `kill_f` = `kill_d` = 1 and `kill_x` = `kill_m` = 0. It discards any cause carried by the instructions in fetch and decode.
- R10: While `pipe_stall` is high, nothing is committed and carried causes hold their place. The commit happens in the first unstalled cycle.
- R11: An interrupt is taken with cause 5 only when `m_valid` is high, the pipeline is not stalled, and no other cause is present.
- R12: On the edge after a commit, `exc_taken` is high for exactly one cycle, with `exc_id` giving the cause and `epc` giving the `m_pc` of the commit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pipe_stall | input | 1 | Whole pipeline held this cycle |
| f_valid | input | 1 | Fetch stage holds an instruction |
| f_itlb_miss | input | 1 | Instruction translation miss in fetch |
| x_valid | input | 1 | Execute stage holds an instruction |
| x_fault | input | 1 | Fault raised in execute |
| x_branch_flush | input | 1 | Taken/mispredicted branch in execute |
| x_branch_target | input | PC_W | Branch redirect address |
| m_valid | input | 1 | Memory stage holds an instruction |
| m_pc | input | PC_W | PC of the memory-stage instruction |
| m_dtlb_miss | input | 1 | Data translation miss or permission fault |
| dbus_err | input | 1 | Data bus error response |
| dbus_cyc | input | 1 | Data bus cycle active |
| irq | input | 1 | Interrupt request |
| exc_base | input | PC_W | Handler vector base |
| kill_f | output | 1 | Kill fetch |
| kill_d | output | 1 | Kill decode |
| kill_x | output | 1 | Kill execute |
| kill_m | output | 1 | Kill memory (exception commit) |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | PC_W | Redirect address |
| exc_taken | output | 1 | One-cycle pulse after a commit |
| exc_id | output | 3 | Cause code of the last commit |
| epc | output | PC_W | PC of the last faulting instruction |

## Verification
The hardest situation to reach is a cause that is already in flight when something else happens in the pipeline. This includes a fetch miss still in decode when a branch flushes it, a fetch miss arriving at memory while the pipeline stalls, and a bus error latched during a stall that then meets a data translation miss. The directed tasks place the fetch-side request a counted number of unstalled edges ahead. They then raise the competing event in the exact cycle the carried cause sits in the targeted stage. Afterwards they keep `m_valid` high for several cycles to show that a discarded cause never resurfaces.

// File: rtl/pexc_pkg.sv
package pexc_pkg;
    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_ITLB = 3'd1,
        CAUSE_DTLB = 3'd2,
        CAUSE_DBUS = 3'd3,
        CAUSE_XFLT = 3'd4,
        CAUSE_IRQ  = 3'd5
    } cause_e;

    localparam int unsigned VEC_SHIFT   = 5;
    localparam int unsigned CARRY_DEPTH = 3;
endpackage

// File: rtl/pexc_tag_pipe.sv
module pexc_tag_pipe
    import pexc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   advance,
    input  logic   flush_all,
    input  logic   flush_front,
    input  logic   f_miss,
    input  logic   x_flt,
    output cause_e m_tag
);
    localparam int unsigned IDX_D = 0;
    localparam int unsigned IDX_X = 1;
    localparam int unsigned IDX_M = CARRY_DEPTH - 1;

    cause_e tag_d [CARRY_DEPTH];
    cause_e tag_q [CARRY_DEPTH];

    always_comb begin
        for (int i = 0; i < CARRY_DEPTH; i++) tag_d[i] = tag_q[i];
        if (flush_all) begin
            for (int i = 0; i < CARRY_DEPTH; i++) tag_d[i] = CAUSE_NONE;
        end else if (advance) begin
            tag_d[IDX_D] = (!flush_front && f_miss) ? CAUSE_ITLB : CAUSE_NONE;
            tag_d[IDX_X] = flush_front ? CAUSE_NONE : tag_q[IDX_D];
            if (tag_q[IDX_X] != CAUSE_NONE)
                tag_d[IDX_M] = tag_q[IDX_X];
            else
                tag_d[IDX_M] = x_flt ? CAUSE_XFLT : CAUSE_NONE;
        end
    end

    generate
        for (genvar g = 0; g < CARRY_DEPTH; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tag_q[g] <= CAUSE_NONE;
                else        tag_q[g] <= tag_d[g];
            end
        end
    endgenerate

    assign m_tag = tag_q[IDX_M];
endmodule

// File: rtl/pexc_select.sv
module pexc_select
    import pexc_pkg::*;
(
    input  logic   m_valid,
    input  logic   stall,
    input  logic   dbus_seen,
    input  logic   dtlb_miss,
    input  cause_e carried,
    input  logic   irq,
    output logic   take,
    output cause_e cause
);
    always_comb begin
        cause = CAUSE_NONE;
        if (m_valid && !stall) begin
            if (dbus_seen)                 cause = CAUSE_DBUS;
            else if (dtlb_miss)            cause = CAUSE_DTLB;
            else if (carried != CAUSE_NONE) cause = carried;
            else if (irq)                  cause = CAUSE_IRQ;
        end
        take = (cause != CAUSE_NONE);
    end
endmodule

// File: rtl/pexc_arbiter.sv
module pexc_arbiter
    import pexc_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pipe_stall,
    input  logic            f_valid,
    input  logic            f_itlb_miss,
    input  logic            x_valid,
    input  logic            x_fault,
    input  logic            x_branch_flush,
    input  logic [PC_W-1:0] x_branch_target,
    input  logic            m_valid,
    input  logic [PC_W-1:0] m_pc,
    input  logic            m_dtlb_miss,
    input  logic            dbus_err,
    input  logic            dbus_cyc,
    input  logic            irq,
    input  logic [PC_W-1:0] exc_base,
    output logic            kill_f,
    output logic            kill_d,
    output logic            kill_x,
    output logic            kill_m,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic            exc_taken,
    output logic [2:0]      exc_id,
    output logic [PC_W-1:0] epc
);
    typedef struct packed {
        logic            seen;
        logic            taken;
        cause_e          id;
        logic [PC_W-1:0] epc;
    } state_t;

    state_t state_d, state_q;
    logic   take;
    logic   br_act;
    cause_e cause;
    cause_e m_tag;

    assign br_act = x_branch_flush && !pipe_stall;

    pexc_tag_pipe u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (!pipe_stall),
        .flush_all   (take),
        .flush_front (br_act),
        .f_miss      (f_valid && f_itlb_miss),
        .x_flt       (x_valid && x_fault),
        .m_tag       (m_tag)
    );

    pexc_select u_sel (
        .m_valid   (m_valid),
        .stall     (pipe_stall),
        .dbus_seen (state_q.seen),
        .dtlb_miss (m_dtlb_miss),
        .carried   (m_tag),
        .irq       (irq),
        .take      (take),
        .cause     (cause)
    );

    always_comb begin
        state_d       = state_q;
        state_d.seen  = (state_q.seen && !take) || (dbus_err && dbus_cyc);
        state_d.taken = take;
        if (take) begin
            state_d.id  = cause;
            state_d.epc = m_pc;
        end

        kill_m = take;
        kill_x = take;
        kill_d = take || br_act;
        kill_f = take || br_act;
        redirect_valid = take || br_act;
        if (take)
            redirect_pc = exc_base + (PC_W'(cause) << VEC_SHIFT);
        else if (br_act)
            redirect_pc = x_branch_target;
        else
            redirect_pc = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.seen  <= 1'b0;
            state_q.taken <= 1'b0;
            state_q.id    <= CAUSE_NONE;
            state_q.epc   <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign exc_taken = state_q.taken;
    assign exc_id    = state_q.id;
    assign epc       = state_q.epc;
endmodule

// File: rtl/pexc_arbiter_chk.sv
module pexc_arbiter_chk #(
    parameter int unsigned PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pipe_stall,
    input logic            irq,
    input logic [PC_W-1:0] m_pc,
    input logic [PC_W-1:0] exc_base,
    input logic            x_branch_flush,
    input logic [PC_W-1:0] x_branch_target,
    input logic            kill_f,
    input logic            kill_d,
    input logic            kill_x,
    input logic            kill_m,
    input logic            redirect_valid,
    input logic [PC_W-1:0] redirect_pc,
    input logic            exc_taken,
    input logic [2:0]      exc_id,
    input logic [PC_W-1:0] epc
);
    AST_KILL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        kill_m |-> (kill_x && kill_d && kill_f && redirect_valid)); // R4

    AST_NO_COMMIT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_stall |-> !kill_m); // R10

    AST_TAKEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        kill_m |=> exc_taken); // R12

    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (epc == $past(m_pc))); // R12

    AST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> ($past(redirect_pc) ==
                       $past(exc_base) + ({{(PC_W-3){1'b0}}, exc_id} << 5))); // R8

    AST_BRANCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (x_branch_flush && !pipe_stall && !kill_m) |->
        (redirect_pc == x_branch_target && kill_f && kill_d && !kill_x)); // R9

    AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (exc_id >= 3'd1 && exc_id <= 3'd5)); // R6

    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && exc_id == 3'd5) |-> $past(irq)); // R11
endmodule

bind pexc_arbiter pexc_arbiter_chk #(.PC_W(PC_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .pipe_stall      (pipe_stall),
    .irq             (irq),
    .m_pc            (m_pc),
    .exc_base        (exc_base),
    .x_branch_flush  (x_branch_flush),
    .x_branch_target (x_branch_target),
    .kill_f          (kill_f),
    .kill_d          (kill_d),
    .kill_x          (kill_x),
    .kill_m          (kill_m),
    .redirect_valid  (redirect_valid),
    .redirect_pc     (redirect_pc),
    .exc_taken       (exc_taken),
    .exc_id          (exc_id),
    .epc             (epc)
);

// File: tb/pexc_arbiter_tb_top.sv
`timescale 1ns/1ps
module pexc_arbiter_tb_top;
    localparam int PC_W = 32;
    localparam logic [PC_W-1:0] BASE = 32'h0000_8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pipe_stall, f_valid, f_itlb_miss, x_valid, x_fault, x_branch_flush;
    logic [PC_W-1:0] x_branch_target, m_pc, exc_base;
    logic m_valid, m_dtlb_miss, dbus_err, dbus_cyc, irq;
    logic kill_f, kill_d, kill_x, kill_m, redirect_valid, exc_taken;
    logic [PC_W-1:0] redirect_pc, epc;
    logic [2:0] exc_id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pexc_arbiter #(.PC_W(PC_W)) dut_i (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        pipe_stall = 0; f_valid = 0; f_itlb_miss = 0; x_valid = 0; x_fault = 0;
        x_branch_flush = 0; x_branch_target = 32'h0; m_valid = 0; m_pc = 32'h0;
        m_dtlb_miss = 0; dbus_err = 0; dbus_cyc = 0; irq = 0; exc_base = BASE;
    endtask

    task automatic drain();
        idle();
        repeat (4) cyc();
    endtask

    task automatic t_reset();
        #1;
        chk("R1 kill_m", kill_m, 0);
        chk("R1 kill_f", kill_f, 0);
        chk("R1 redirect_valid", redirect_valid, 0);
        chk("R1 exc_taken", exc_taken, 0);
        chk("R1 epc", epc, 0);
        chk("R1 exc_id", exc_id, 0);
    endtask

    task automatic t_dtlb_vs_itlb();
        m_valid = 1; m_pc = 32'h1000; m_dtlb_miss = 1; f_valid = 1; f_itlb_miss = 1;
        #1;
        chk("R4 kill_m", kill_m, 1);
        chk("R4 kill all", {kill_f, kill_d, kill_x}, 3'b111);
        chk("R8 vector", redirect_pc, BASE + 2*32);
        cyc();
        m_dtlb_miss = 0; f_valid = 0; f_itlb_miss = 0; m_pc = 32'h1004;
        #1;
        chk("R12 taken", exc_taken, 1);
        chk("R4 id", exc_id, 2);
        chk("R12 epc", epc, 32'h1000);
        cyc();
        chk("R12 one pulse", exc_taken, 0);
        for (int i = 0; i < 4; i++) begin
            #1 chk("R6 fetch miss dropped", kill_m, 0);
            cyc();
        end
        drain();
    endtask

    task automatic t_itlb();
        m_valid = 1; m_pc = 32'h2000; f_valid = 1; f_itlb_miss = 1;
        cyc();
        f_valid = 0; f_itlb_miss = 0;
        #1 chk("R2 not yet (D)", kill_m, 0);
        cyc();
        #1 chk("R2 not yet (X)", kill_m, 0);
        cyc();
        m_pc = 32'h2040;
        #1 chk("R2 commit in M", kill_m, 1);
        chk("R8 vector itlb", redirect_pc, BASE + 1*32);
        cyc();
        chk("R2 id", exc_id, 1);
        chk("R12 epc itlb", epc, 32'h2040);
        drain();
    endtask

    task automatic t_stall();
        m_valid = 1; m_pc = 32'h3000; f_valid = 1; f_itlb_miss = 1;
        cyc();
        f_valid = 0; f_itlb_miss = 0;
        pipe_stall = 1;
        cyc();
        #1 chk("R10 stalled, held", kill_m, 0);
        pipe_stall = 0;
        cyc(); cyc();
        pipe_stall = 1;
        #1 chk("R10 no commit while stalled", kill_m, 0);
        cyc();
        #1 chk("R10 still stalled", kill_m, 0);
        pipe_stall = 0;
        #1 chk("R10 commit after stall", kill_m, 1);
        cyc();
        chk("R10 id", exc_id, 1);
        drain();
    endtask

    task automatic t_xfault();
        m_valid = 1; m_pc = 32'h4000; x_valid = 1; x_fault = 1;
        #1 chk("R3 not in X", kill_m, 0);
        cyc();
        x_valid = 0; x_fault = 0; m_pc = 32'h4004;
        #1 chk("R3 commit", kill_m, 1);
        cyc();
        chk("R3 id", exc_id, 4);
        chk("R3 epc", epc, 32'h4004);
        drain();
    endtask

    task automatic t_x_and_m();
        m_valid = 1; m_pc = 32'h5000; m_dtlb_miss = 1; x_valid = 1; x_fault = 1;
        cyc();
        m_dtlb_miss = 0; x_valid = 0; x_fault = 0; m_pc = 32'h5004;
        chk("R7 memory fault wins", exc_id, 2);
        #1 chk("R7 execute fault dropped", kill_m, 0);
        cyc();
        #1 chk("R7 still dropped", kill_m, 0);
        drain();
    endtask

    task automatic t_dbus();
        m_valid = 1; m_pc = 32'h6000; dbus_err = 1; dbus_cyc = 0;
        cyc();
        dbus_err = 0;
        #1 chk("R5 err without cyc ignored", kill_m, 0);
        dbus_err = 1; dbus_cyc = 1; pipe_stall = 1;
        cyc();
        dbus_err = 0; dbus_cyc = 0;
        #1 chk("R5 seen but stalled", kill_m, 0);
        cyc();
        pipe_stall = 0; m_dtlb_miss = 1;
        #1 chk("R5 commit", kill_m, 1);
        chk("R6 bus error vector", redirect_pc, BASE + 3*32);
        cyc();
        m_dtlb_miss = 0;
        chk("R6 bus error over dtlb", exc_id, 3);
        #1 chk("R5 flag cleared", kill_m, 0);
        drain();
    endtask

    task automatic t_branch();
        x_branch_flush = 1; x_branch_target = 32'h7777_0000; m_valid = 1;
        #1;
        chk("R9 target", redirect_pc, 32'h7777_0000);
        chk("R9 kills", {kill_f, kill_d, kill_x, kill_m}, 4'b1100);
        x_branch_flush = 0;
        f_valid = 1; f_itlb_miss = 1;
        cyc();
        f_valid = 0; f_itlb_miss = 0; x_branch_flush = 1;
        cyc();
        x_branch_flush = 0;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R9 carried cause discarded", kill_m, 0);
            cyc();
        end
        x_branch_flush = 1; m_dtlb_miss = 1;
        #1 chk("R8 exception beats branch", redirect_pc, BASE + 2*32);
        chk("R8 kill_x", kill_x, 1);
        drain();
    endtask

    task automatic t_irq();
        irq = 1; m_valid = 0;
        #1 chk("R11 no boundary", kill_m, 0);
        m_valid = 1; m_pc = 32'h9000; m_dtlb_miss = 1;
        cyc();
        m_dtlb_miss = 0;
        chk("R11 lower than dtlb", exc_id, 2);
        m_pc = 32'h9010;
        #1 chk("R11 commit", kill_m, 1);
        chk("R11 vector", redirect_pc, BASE + 5*32);
        cyc();
        irq = 0;
        chk("R11 id", exc_id, 5);
        chk("R12 epc irq", epc, 32'h9010);
        drain();
    endtask

    initial begin
        #150000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        cyc();
        t_dtlb_vs_itlb();
        t_itlb();
        t_stall();
        t_xfault();
        t_x_and_m();
        t_dbus();
        t_branch();
        t_irq();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule